// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block derives a serial bit clock and a periodic frame-sync pulse from a reference clock. It is meant for the master side of an audio serial port. A divider sets the bit-clock rate. Two counts, each programmed as the value minus one in bit clocks, set the frame length and how long the sync pulse stays active. With a frame of 32 bit clocks and a pulse of 16 bit clocks, the sync output becomes a symmetric left/right clock for 16-bit stereo samples.

The generator and the frame-sync logic have separate enables. The generator must be running for frame sync to run, and dropping either enable returns the sync output to its inactive level. Each output has its own polarity bit. The block also gives a one-cycle strobe that marks the start of every bit-clock period, so a serial data shifter in the same reference-clock domain can launch or capture on it. Configuration is taken in only while both enables are low. A change therefore lands cleanly, at the next start after a full stop.

Top module: `fsync_gen`

## Requirements
- R1: While reset is asserted, and after release with both enables low and both polarity bits 0, `bclk`, `bclk_edge` and `fsync` are all 0.
- R2: A running bit clock has a period of `cfg_div`+1 reference cycles. Before polarity, it is high for the first ceil((`cfg_div`+1)/2) cycles of each period and low for the rest. `bclk_edge` is 1 for exactly the first cycle of each period.
- R3: Frame sync repeats every `cfg_period`+1 bit clocks with no further stimulus. `cfg_period` is 12 bits wide, so frame lengths run from 1 to 4096.
- R4: Before polarity, `fsync` is active for the first `cfg_width`+1 bit clocks of each frame. If `cfg_width` is at least `cfg_period`, it stays active continuously.
- R5: When both enables rise together, the first bit clock and the first frame begin in the reference cycle after the enabling edge. In that cycle `bclk_edge` is 1 and `fsync` is active.
- R6: `cfg_bclk_inv`=1 inverts `bclk`, and `cfg_fs_inv`=1 inverts `fsync` (1 = active low). The inactive levels while stopped are the inverted levels.
- R7: `fsync` is driven only while both enables are set. Clearing `fs_en` returns `fsync` to its inactive level on the next cycle while `bclk` keeps running. Clearing `gen_en` returns `bclk` to its idle level, holds `bclk_edge` at 0 and makes `fsync` inactive on the next cycle.
- R8: Setting `fs_en` again while the generator runs restarts the frame at slot 0 on a bit-clock boundary, so the first active `fsync` cycle coincides with `bclk_edge`.
- R9: All configuration inputs (divider, period, width, both polarity bits) are sampled only on clock edges where both enables are low. Changes made while either enable is set have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | Bit-clock divider minus one |
| cfg_period | input | 12 | Frame length in bit clocks minus one |
| cfg_width | input | 12 | Sync pulse length in bit clocks minus one |
| cfg_bclk_inv | input | 1 | Invert the bit-clock output |
| cfg_fs_inv | input | 1 | Frame sync active low when 1 |
| gen_en | input | 1 | Bit-clock generator enable |
| fs_en | input | 1 | Frame-sync enable |
| bclk | output | 1 | Bit clock |
| bclk_edge | output | 1 | One-cycle strobe at the start of each bit clock |
| fsync | output | 1 | Frame-sync output |

## Verification
The bench walks a set of configurations that covers:
- a divider of 0, where the bit clock degenerates to a constant with a strobe every cycle;
- a divider of 255, where an 8-bit counter that overflows would shorten the period;
- a pulse width equal to the period, which must give a sync output that never goes inactive;
- a one-slot frame.

For each configuration it predicts every cycle of all three outputs. An off-by-one in either minus-one field shows up there as a frame or pulse one bit clock too long or too short.

While each configuration runs, the configuration inputs are scrambled. A design that did not hold its settings would drift from the prediction straight away.

Directed tests drop and restore each enable separately. A frame restart that did not wait for a bit-clock boundary would put the first sync cycle away from the strobe. A generator stop that left frame sync alone would keep `fsync` active.

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int DIV_W = 8,
  parameter int FP_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [FP_W-1:0]  cfg_period,
  input  logic [FP_W-1:0]  cfg_width,
  input  logic             cfg_bclk_inv,
  input  logic             cfg_fs_inv,
  input  logic             gen_en,
  input  logic             fs_en,
  output logic             bclk,
  output logic             bclk_edge,
  output logic             fsync
);
  localparam int HW = DIV_W + 1;
  localparam logic [FP_W-1:0] PER_RST = FP_W'(31);
  localparam logic [FP_W-1:0] WID_RST = FP_W'(15);

  logic [DIV_W-1:0] div_s, dcnt;
  logic [FP_W-1:0]  per_s, wid_s, fcnt;
  logic             binv_s, finv_s, run, fs_run;

  wire            both_off = !gen_en && !fs_en;
  wire            fs_on    = gen_en && fs_en;
  wire            bit_next = gen_en && (!run || dcnt == div_s);
  wire [HW-1:0]   half     = ({1'b0, div_s} + HW'(2)) >> 1;

  assign bclk_edge = run && dcnt == '0;
  assign bclk      = (run && {1'b0, dcnt} < half) ^ binv_s;
  assign fsync     = (fs_run && fcnt <= wid_s) ^ finv_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_s  <= '0;
      per_s  <= PER_RST;
      wid_s  <= WID_RST;
      binv_s <= 1'b0;
      finv_s <= 1'b0;
    end else if (both_off) begin
      div_s  <= cfg_div;
      per_s  <= cfg_period;
      wid_s  <= cfg_width;
      binv_s <= cfg_bclk_inv;
      finv_s <= cfg_fs_inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      dcnt <= '0;
    end else if (!gen_en) begin
      run  <= 1'b0;
      dcnt <= '0;
    end else if (!run || dcnt == div_s) begin
      run  <= 1'b1;
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_run <= 1'b0;
      fcnt   <= '0;
    end else if (!fs_on) begin
      fs_run <= 1'b0;
      fcnt   <= '0;
    end else if (bit_next) begin
      if (!fs_run) begin
        fs_run <= 1'b1;
        fcnt   <= '0;
      end else if (fcnt == per_s) begin
        fcnt <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  // R7
  fs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_on |=> !fs_run && fsync == finv_s);

  // R7
  gen_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !bclk_edge && bclk == binv_s);

  // R5 R8
  fs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_run) |-> bclk_edge);

  // R2
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_edge && div_s != '0 && gen_en |=> !bclk_edge);

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_run |-> fcnt <= per_s);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !both_off |=> $stable(div_s) && $stable(per_s) && $stable(wid_s)
                  && $stable(binv_s) && $stable(finv_s));
endmodule

// File: tb/fsync_gen_bench.sv
module fsync_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic [11:0] cfg_period = '0;
  logic [11:0] cfg_width = '0;
  logic        cfg_bclk_inv = 1'b0;
  logic        cfg_fs_inv = 1'b0;
  logic        gen_en = 1'b0;
  logic        fs_en = 1'b0;
  logic        bclk, bclk_edge, fsync;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  fsync_gen u_fsync_gen (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_period(cfg_period),
    .cfg_width(cfg_width), .cfg_bclk_inv(cfg_bclk_inv), .cfg_fs_inv(cfg_fs_inv),
    .gen_en(gen_en), .fs_en(fs_en), .bclk(bclk), .bclk_edge(bclk_edge),
    .fsync(fsync)
  );

  // {div, period, width, bclk_inv, fs_inv}
  localparam int NV = 7;
  localparam logic [33:0] VEC [NV] = '{
    {8'd1,   12'd31, 12'd15, 1'b0, 1'b0},
    {8'd0,   12'd7,  12'd0,  1'b0, 1'b0},
    {8'd2,   12'd5,  12'd2,  1'b1, 1'b0},
    {8'd3,   12'd9,  12'd0,  1'b0, 1'b1},
    {8'd4,   12'd3,  12'd3,  1'b0, 1'b0},
    {8'd0,   12'd0,  12'd0,  1'b1, 1'b1},
    {8'd255, 12'd1,  12'd0,  1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(input logic [33:0] v);
    int d, p, w, bad_b, bad_e, bad_f, first_b, first_e, first_f, len;
    logic bi, fi, eb, ee, ef;
    d = int'(v[33:26]); p = int'(v[25:14]); w = int'(v[13:2]);
    bi = v[1]; fi = v[0];
    bad_b = 0; bad_e = 0; bad_f = 0;
    first_b = -1; first_e = -1; first_f = -1;
    gen_en = 1'b0; fs_en = 1'b0;
    cfg_div = v[33:26]; cfg_period = v[25:14]; cfg_width = v[13:2];
    cfg_bclk_inv = bi; cfg_fs_inv = fi;
    @(negedge clk);
    @(negedge clk);
    gen_en = 1'b1; fs_en = 1'b1;
    @(negedge clk);
    // R9: scramble configuration while running
    cfg_div = ~v[33:26]; cfg_period = 12'd2; cfg_width = 12'd1;
    cfg_bclk_inv = ~bi; cfg_fs_inv = ~fi;
    len = 2 * (p + 1) * (d + 1);
    for (int k = 0; k < len; k++) begin
      int slot, pos;
      slot = k / (d + 1);
      pos  = k % (d + 1);
      eb = (pos < (d + 2) / 2) ^ bi;
      ee = (pos == 0);
      ef = ((slot % (p + 1)) <= w) ^ fi;
      if (bclk !== eb) begin bad_b++; if (first_b < 0) first_b = k; end
      if (bclk_edge !== ee) begin bad_e++; if (first_e < 0) first_e = k; end
      if (fsync !== ef) begin bad_f++; if (first_f < 0) first_f = k; end
      @(negedge clk);
    end
    n_chk += 3;
    if (bad_b != 0) begin
      n_bad++;
      $display("FAIL R2 R6 R9 bclk div=%0d: %0d bad cycles, first at cycle %0d (got %b expected %b)",
               d, bad_b, first_b, ~((first_b % (d + 1) < (d + 2) / 2) ^ bi),
               (first_b % (d + 1) < (d + 2) / 2) ^ bi);
    end
    if (bad_e != 0) begin
      n_bad++;
      $display("FAIL R2 R5 bclk_edge div=%0d: %0d bad cycles, first at cycle %0d (got %b expected %b)",
               d, bad_e, first_e, ~(first_e % (d + 1) == 0), first_e % (d + 1) == 0);
    end
    if (bad_f != 0) begin
      n_bad++;
      $display("FAIL R3 R4 R5 R6 fsync div=%0d per=%0d wid=%0d: %0d bad cycles, first at cycle %0d",
               d, p, w, bad_f, first_f);
    end
    gen_en = 1'b0; fs_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int edges, hit;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 bclk in reset", bclk, 1'b0);
    check("R1 edge in reset", bclk_edge, 1'b0);
    check("R1 fsync in reset", fsync, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 bclk idle", bclk, 1'b0);
    check("R1 fsync idle", fsync, 1'b0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R7 / R8 directed: div=3, period=7, width=1, normal polarity
    cfg_div = 8'd3; cfg_period = 12'd7; cfg_width = 12'd1;
    cfg_bclk_inv = 1'b0; cfg_fs_inv = 1'b0;
    @(negedge clk);
    gen_en = 1'b1; fs_en = 1'b1;
    repeat (6) @(negedge clk);
    fs_en = 1'b0;
    @(negedge clk);
    check("R7 fsync inactive after fs_en clear", fsync, 1'b0);
    edges = 0;
    for (int k = 0; k < 8; k++) begin
      if (bclk_edge) edges++;
      if (fsync) edges = edges + 100;
      @(negedge clk);
    end
    n_chk++;
    if (edges != 2) begin
      n_bad++;
      $display("FAIL R7 bclk keeps running with fs off: got %0d expected 2", edges);
    end
    fs_en = 1'b1;
    @(negedge clk);
    hit = 0;
    for (int k = 0; k < 8; k++) begin
      if (hit == 0 && fsync) begin
        hit = 1;
        check("R8 frame restart aligned to bit boundary", bclk_edge, 1'b1);
      end
      @(negedge clk);
    end
    check("R8 frame restarted", hit[0], 1'b1);
    gen_en = 1'b0;
    @(negedge clk);
    check("R7 bclk idle after gen_en clear", bclk, 1'b0);
    check("R7 edge low after gen_en clear", bclk_edge, 1'b0);
    check("R7 fsync inactive after gen_en clear", fsync, 1'b0);
    fs_en = 1'b0;
    @(negedge clk);

    // R6 inactive levels follow polarity while stopped
    cfg_bclk_inv = 1'b1; cfg_fs_inv = 1'b1;
    @(negedge clk);
    check("R6 inverted bclk idle", bclk, 1'b1);
    check("R6 inverted fsync idle", fsync, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule